// File: doc/BRIEF.md
# Performance Monitor Counter Unit

The block is a register-programmed performance monitor. It holds one free-running cycle counter and a parameterised bank of event counters, four by default. Surrounding logic feeds it a vector of single-cycle event pulses and a non-invasive debug-enable level. Software reaches the unit over a simple register bus that carries a write strobe, a word address, write data, a privilege flag and combinational read data.

Event counters are not mapped one by one. Software first writes a counter number into a selection register. The type register and the count register then act on that counter: the type picks which pulse input the counter listens to, and the count register reads or loads its value. A count-enable mask with separate set and clear addresses turns individual counters on and off. A control register holds the global enable and two self-clearing reset strobes. A user-access register decides whether unprivileged accesses are allowed.

Top module: `perf_mon_unit`

## Requirements
- R1: Control register bit 0 is the global enable. While it is 0, neither the cycle counter nor any event counter advances.
- R2: Writing a control word with bit 1 set clears every event counter to 0 on that edge. Bit 1 reads back as 0.
- R3: Writing a control word with bit 2 set clears the cycle counter to 0 on that edge. Bit 2 reads back as 0. The word 0x7 enables the unit and clears both kinds of counter in one access.
- R4: In the enable mask, bit 31 enables the cycle counter and bit N enables event counter N. Writing to the set address ORs the data into the mask, and writing to the clear address removes the bits written as 1. Zero bits have no effect. Both addresses read back the mask, with unused bits reading 0.
- R5: After counter number N is written to the selection register, writes to the type register and the count register go to counter N. Reads of those registers return counter N's type and value. The selection register reads back its low 5 bits.
- R6: An event counter advances by one on each cycle in which the pulse input indexed by its type is high. A type value of 8 or more never counts.
- R7: Event counters advance only while the debug-enable input is high. The cycle counter advances on every cycle in which the unit and mask bit 31 are on, whatever the debug-enable level.
- R8: Bit 0 of the user-access register permits unprivileged accesses. While it is 0, unprivileged writes are ignored and unprivileged reads return 0. Privileged accesses always work. Only privileged writes change the user-access register.
- R9: Counters wrap from 0xFFFFFFFF to 0.
- R10: With a selection of 4 or more, type and count reads return 0, and type and count writes change no counter.
- R11: Every register resets to 0. A reset strobe beats a software load of the same counter, and a software load beats an increment in the same cycle.
- R12: The cycle counter can be read and loaded at its own address.
- R13: Word addresses are 0 control, 1 enable-set, 2 enable-clear, 3 selection, 4 event type, 5 event count, 6 cycle counter and 7 user access. Addresses 8 to 15 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_count_en | input | 1 | Non-invasive debug enable; gates event counting |
| evt_pulse | input | 8 | Single-cycle event pulses from surrounding logic |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | 1 for a privileged access, 0 for an unprivileged one |
| bus_rdata | output | 32 | Combinational read data for bus_addr |

## Verification
On every cycle, the assertions check the following:
- The reset strobes leave their counter at zero on the next edge.
- A counter whose gate, type or enable keeps it idle holds its value.
- Any counter moves by at most one step unless it is loaded.
- A blocked unprivileged access neither writes a register nor returns data.

Other behaviours can only be shown by the bench's scenarios, because they depend on the value software expects to read back:
- the indirection through the selection register;
- the exact totals after mixed pulse patterns;
- wrap-around;
- the precedence of a reset strobe over a load, and of a load over a pulse in the same cycle;
- the effect of out-of-range selections and unused addresses.

// File: rtl/pmu_pkg.sv
`timescale 1ns/1ps
package pmu_pkg;
   localparam int ADDR_W = 4;

   typedef enum logic [ADDR_W-1:0] {
      RA_CTRL  = 4'd0,
      RA_ENSET = 4'd1,
      RA_ENCLR = 4'd2,
      RA_SEL   = 4'd3,
      RA_TYPE  = 4'd4,
      RA_COUNT = 4'd5,
      RA_CYC   = 4'd6,
      RA_UACC  = 4'd7
   } reg_addr_e;

   typedef struct packed {
      logic ctrl;
      logic enset;
      logic enclr;
      logic sel;
      logic typ;
      logic cnt;
      logic cyc;
      logic uacc;
   } wr_strobe_t;
endpackage

// File: rtl/pmu_ctl_regs.sv
`timescale 1ns/1ps
module pmu_ctl_regs
   import pmu_pkg::*;
#(
   parameter int NUM_CTR = 4,
   parameter int DATA_W  = 32,
   parameter int SEL_W   = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_we,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [DATA_W-1:0]      bus_wdata,
   input  logic                   bus_priv,
   output wr_strobe_t             stb,
   output logic                   access_ok,
   output logic                   unit_en,
   output logic                   ev_clr,
   output logic                   cyc_clr,
   output logic [NUM_CTR-1:0]     ev_mask,
   output logic                   cyc_mask,
   output logic [SEL_W-1:0]       sel_q,
   output logic                   sel_ok,
   output logic                   usr_en,
   output logic [DATA_W-1:0]      ctl_rdata
);
   localparam int CYC_BIT = DATA_W - 1;

   logic we_ok;

   assign access_ok = bus_priv | usr_en;
   assign we_ok     = bus_we & access_ok;

   always_comb begin
      stb       = '0;
      stb.ctrl  = we_ok && (bus_addr == RA_CTRL);
      stb.enset = we_ok && (bus_addr == RA_ENSET);
      stb.enclr = we_ok && (bus_addr == RA_ENCLR);
      stb.sel   = we_ok && (bus_addr == RA_SEL);
      stb.typ   = we_ok && (bus_addr == RA_TYPE);
      stb.cnt   = we_ok && (bus_addr == RA_COUNT);
      stb.cyc   = we_ok && (bus_addr == RA_CYC);
      stb.uacc  = bus_we && bus_priv && (bus_addr == RA_UACC);
   end

   // reset strobes are pulses, never stored
   assign ev_clr  = stb.ctrl & bus_wdata[1];
   assign cyc_clr = stb.ctrl & bus_wdata[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unit_en  <= 1'b0;
         ev_mask  <= '0;
         cyc_mask <= 1'b0;
         sel_q    <= '0;
         sel_ok   <= 1'b1;
         usr_en   <= 1'b0;
      end else begin
         if (stb.ctrl) unit_en <= bus_wdata[0];
         if (stb.enset) begin
            ev_mask  <= ev_mask | bus_wdata[NUM_CTR-1:0];
            cyc_mask <= cyc_mask | bus_wdata[CYC_BIT];
         end else if (stb.enclr) begin
            ev_mask  <= ev_mask & ~bus_wdata[NUM_CTR-1:0];
            cyc_mask <= cyc_mask & ~bus_wdata[CYC_BIT];
         end
         if (stb.sel) begin
            sel_q  <= bus_wdata[SEL_W-1:0];
            sel_ok <= (bus_wdata < DATA_W'(NUM_CTR));
         end
         if (stb.uacc) usr_en <= bus_wdata[0];
      end
   end

   always_comb begin
      ctl_rdata = '0;
      unique case (bus_addr)
         RA_CTRL:  ctl_rdata[0] = unit_en;
         RA_ENSET,
         RA_ENCLR: begin
            ctl_rdata[NUM_CTR-1:0] = ev_mask;
            ctl_rdata[CYC_BIT]     = cyc_mask;
         end
         RA_SEL:   ctl_rdata[SEL_W-1:0] = sel_q;
         RA_UACC:  ctl_rdata[0] = usr_en;
         default:  ctl_rdata = '0;
      endcase
   end

   AST_USER_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_priv && !usr_en) |-> (stb == '0)); // R8
   AST_ENSET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      stb.enset |=> ((ev_mask & $past(ev_mask)) == $past(ev_mask))); // R4
   AST_ENCLR_NO_ADD: assert property (@(posedge clk) disable iff (!rst_n)
      stb.enclr |=> ((ev_mask | $past(ev_mask)) == $past(ev_mask))); // R4
endmodule

// File: rtl/pmu_evt_ctr.sv
`timescale 1ns/1ps
module pmu_evt_ctr #(
   parameter int CNT_W   = 32,
   parameter int EVT_W   = 8,
   parameter int NUM_EVT = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               cnt_wr,
   input  logic [CNT_W-1:0]   cnt_wdata,
   input  logic               typ_wr,
   input  logic [EVT_W-1:0]   typ_wdata,
   input  logic               gate,
   input  logic [NUM_EVT-1:0] evt_in,
   output logic [CNT_W-1:0]   count,
   output logic [EVT_W-1:0]   evt_type
);
   localparam int IDX_W = $clog2(NUM_EVT);

   logic type_ok;
   logic hit;

   assign type_ok = (evt_type < EVT_W'(NUM_EVT));
   assign hit     = gate && type_ok && evt_in[evt_type[IDX_W-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count    <= '0;
         evt_type <= '0;
      end else begin
         if (clr)         count <= '0;
         else if (cnt_wr) count <= cnt_wdata;
         else if (hit)    count <= count + 1'b1;
         if (typ_wr) evt_type <= typ_wdata;
      end
   end

   AST_EV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0)); // R2
   AST_EV_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate && !clr && !cnt_wr) |=> $stable(count)); // R7
   AST_EV_BADTYPE: assert property (@(posedge clk) disable iff (!rst_n)
      (!type_ok && !clr && !cnt_wr) |=> $stable(count)); // R6
   AST_EV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !cnt_wr) |=> ((count == $past(count)) ||
                             (count == CNT_W'($past(count) + 1'b1)))); // R9
endmodule

// File: rtl/pmu_cyc_ctr.sv
`timescale 1ns/1ps
module pmu_cyc_ctr #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             run,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count <= '0;
      else if (clr)    count <= '0;
      else if (wr)     count <= wdata;
      else if (run)    count <= count + 1'b1;
   end

   AST_CYC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0)); // R3
   AST_CYC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clr && !wr) |=> $stable(count)); // R1
   AST_CYC_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clr && !wr) |=> (count == CNT_W'($past(count) + 1'b1))); // R7
endmodule

// File: rtl/perf_mon_unit.sv
`timescale 1ns/1ps
module perf_mon_unit
   import pmu_pkg::*;
#(
   parameter int NUM_CTR = 4,
   parameter int CNT_W   = 32,
   parameter int NUM_EVT = 8,
   parameter int EVT_W   = 8,
   parameter int DATA_W  = 32,
   parameter int SEL_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dbg_count_en,
   input  logic [NUM_EVT-1:0] evt_pulse,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   input  logic               bus_priv,
   output logic [DATA_W-1:0]  bus_rdata
);
   localparam int CIDX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;

   // elaboration-time parameter checks
   generate
      if (NUM_CTR < 1 || NUM_CTR > DATA_W - 1) begin : g_bad_nctr
         $error("NUM_CTR must lie in 1..DATA_W-1");
      end
      if (CNT_W > DATA_W || EVT_W > DATA_W) begin : g_bad_width
         $error("counter and type widths must fit the data bus");
      end
      if (NUM_EVT < 2 || NUM_EVT > (1 << EVT_W)) begin : g_bad_nevt
         $error("NUM_EVT must be at least 2 and addressable by EVT_W");
      end
      if ((1 << SEL_W) <= NUM_CTR || SEL_W > DATA_W) begin : g_bad_sel
         $error("SEL_W too narrow for NUM_CTR");
      end
   endgenerate

   wr_strobe_t           stb;
   logic                 access_ok;
   logic                 unit_en;
   logic                 ev_clr;
   logic                 cyc_clr;
   logic [NUM_CTR-1:0]   ev_mask;
   logic                 cyc_mask;
   logic [SEL_W-1:0]     sel_q;
   logic                 sel_ok;
   logic                 usr_en;
   logic [DATA_W-1:0]    ctl_rdata;
   logic [CNT_W-1:0]     cyc_cnt;
   logic [CNT_W-1:0]     ev_cnt  [NUM_CTR];
   logic [EVT_W-1:0]     ev_type [NUM_CTR];
   logic [CIDX_W-1:0]    sel_idx;
   logic [DATA_W-1:0]    mux_rdata;

   assign sel_idx = sel_q[CIDX_W-1:0];

   pmu_ctl_regs #(
      .NUM_CTR (NUM_CTR),
      .DATA_W  (DATA_W),
      .SEL_W   (SEL_W)
   ) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_priv  (bus_priv),
      .stb       (stb),
      .access_ok (access_ok),
      .unit_en   (unit_en),
      .ev_clr    (ev_clr),
      .cyc_clr   (cyc_clr),
      .ev_mask   (ev_mask),
      .cyc_mask  (cyc_mask),
      .sel_q     (sel_q),
      .sel_ok    (sel_ok),
      .usr_en    (usr_en),
      .ctl_rdata (ctl_rdata)
   );

   pmu_cyc_ctr #(.CNT_W(CNT_W)) u_cyc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cyc_clr),
      .wr    (stb.cyc),
      .wdata (bus_wdata[CNT_W-1:0]),
      .run   (unit_en & cyc_mask),
      .count (cyc_cnt)
   );

   generate
      for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
         logic hit_sel;
         assign hit_sel = sel_ok && (sel_idx == CIDX_W'(i));
         pmu_evt_ctr #(
            .CNT_W   (CNT_W),
            .EVT_W   (EVT_W),
            .NUM_EVT (NUM_EVT)
         ) u_evt (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (ev_clr),
            .cnt_wr    (stb.cnt & hit_sel),
            .cnt_wdata (bus_wdata[CNT_W-1:0]),
            .typ_wr    (stb.typ & hit_sel),
            .typ_wdata (bus_wdata[EVT_W-1:0]),
            .gate      (unit_en & ev_mask[i] & dbg_count_en),
            .evt_in    (evt_pulse),
            .count     (ev_cnt[i]),
            .evt_type  (ev_type[i])
         );
      end
   endgenerate

   always_comb begin
      unique case (bus_addr)
         RA_TYPE:  mux_rdata = sel_ok ? DATA_W'(ev_type[sel_idx]) : '0;
         RA_COUNT: mux_rdata = sel_ok ? DATA_W'(ev_cnt[sel_idx])  : '0;
         RA_CYC:   mux_rdata = DATA_W'(cyc_cnt);
         default:  mux_rdata = ctl_rdata;
      endcase
   end

   assign bus_rdata = access_ok ? mux_rdata : '0;

   AST_USER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_priv && !usr_en) |-> (bus_rdata == '0)); // R8
   AST_STOPPED_CYC: assert property (@(posedge clk) disable iff (!rst_n)
      (!unit_en && !stb.cyc && !cyc_clr) |=> $stable(cyc_cnt)); // R1
endmodule

// File: tb/sim_perf_mon_unit.sv
`timescale 1ns/1ps
module sim_perf_mon_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dbg_count_en = 1'b0;
   logic [7:0]  evt_pulse = '0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_priv = 1'b1;
   logic [31:0] bus_rdata;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk; // 50 MHz

   perf_mon_unit u0 (
      .clk (clk), .rst_n (rst_n), .dbg_count_en (dbg_count_en),
      .evt_pulse (evt_pulse), .bus_we (bus_we), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_priv (bus_priv), .bus_rdata (bus_rdata)
   );

   localparam logic [3:0] A_CTRL = 0, A_ENSET = 1, A_ENCLR = 2, A_SEL = 3,
                          A_TYPE = 4, A_COUNT = 5, A_CYC = 6, A_UACC = 7;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // called at a negedge; returns at the following negedge
   task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic p = 1'b1);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_priv = p;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0; bus_priv = 1'b1;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d, input logic p = 1'b1);
      bus_addr = a; bus_priv = p;
      #2 d = bus_rdata;
      bus_priv = 1'b1;
   endtask

   task automatic pulse(input logic [7:0] v);
      evt_pulse = v;
      @(negedge clk);
      evt_pulse = '0;
   endtask

   task automatic rd_ctr(input int n, output logic [31:0] d);
      wr(A_SEL, n);
      rd(A_COUNT, d);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      for (int a = 0; a < 8; a++) begin
         rd(4'(a), d);
         chk("R11 reset value", d, 32'h0);
      end
   endtask

   task automatic t_control;
      logic [31:0] d;
      wr(A_ENSET, 32'h8000_0000);
      wr(A_CYC, 32'd100);
      repeat (3) @(negedge clk);
      rd(A_CYC, d);  chk("R12 cycle load, R1 idle while disabled", d, 32'd100);
      wr(A_CTRL, 32'h1);
      repeat (4) @(negedge clk);
      wr(A_CTRL, 32'h0);
      rd(A_CYC, d);  chk("R1 cycle count while enabled", d, 32'd105);
      wr(A_CTRL, 32'h7);
      rd(A_CTRL, d); chk("R2 R3 reset bits read 0", d, 32'h1);
      rd(A_CYC, d);  chk("R3 cycle cleared", d, 32'h0);
      wr(A_CTRL, 32'h0);
      rd(A_CYC, d);  chk("R3 cycle restarts", d, 32'h1);
      wr(A_CTRL, 32'h4);
      rd(A_CYC, d);  chk("R3 clear while disabled", d, 32'h0);
   endtask

   task automatic t_mask;
      logic [31:0] d;
      wr(A_ENSET, 32'h5);
      rd(A_ENSET, d); chk("R4 set ORs", d, 32'h8000_0005);
      wr(A_ENSET, 32'h0);
      rd(A_ENSET, d); chk("R4 zero set no effect", d, 32'h8000_0005);
      wr(A_ENCLR, 32'h8000_0001);
      rd(A_ENSET, d); chk("R4 clear bits", d, 32'h4);
      wr(A_ENCLR, 32'h0);
      rd(A_ENCLR, d); chk("R4 zero clear no effect", d, 32'h4);
      wr(A_ENSET, 32'hFFFF_FFFF);
      rd(A_ENCLR, d); chk("R4 unused bits read 0", d, 32'h8000_000F);
   endtask

   task automatic t_events;
      logic [31:0] d;
      dbg_count_en = 1'b1;
      wr(A_SEL, 0); wr(A_TYPE, 2);
      wr(A_SEL, 1); wr(A_TYPE, 5);
      wr(A_SEL, 2); wr(A_TYPE, 9);
      wr(A_SEL, 3); wr(A_TYPE, 2);
      wr(A_SEL, 1);
      rd(A_TYPE, d); chk("R5 type readback", d, 32'd5);
      rd(A_SEL, d);  chk("R5 select readback", d, 32'd1);
      wr(A_CTRL, 32'h3);
      repeat (3) pulse(8'h04);
      repeat (2) pulse(8'h20);
      pulse(8'hFF);
      rd_ctr(0, d); chk("R6 counter0 type2", d, 32'd4);
      rd_ctr(1, d); chk("R5 counter1 type5", d, 32'd3);
      rd_ctr(2, d); chk("R6 type 9 never counts", d, 32'd0);
      rd_ctr(3, d); chk("R6 counter3 type2", d, 32'd4);
      dbg_count_en = 1'b0;
      pulse(8'hFF);
      rd_ctr(0, d); chk("R7 debug-enable gates events", d, 32'd4);
      begin
         logic [31:0] c1, c2;
         rd(A_CYC, c1);
         repeat (3) @(negedge clk);
         rd(A_CYC, c2);
         chk("R7 cycle runs without debug-enable", c2 - c1, 32'd3);
      end
      dbg_count_en = 1'b1;
      wr(A_SEL, 2); wr(A_TYPE, 7);
      pulse(8'h80);
      rd_ctr(2, d); chk("R6 type 7 input", d, 32'd1);
   endtask

   task automatic t_enable_off;
      logic [31:0] d;
      wr(A_CTRL, 32'h0);
      pulse(8'hFF);
      rd_ctr(0, d); chk("R1 events stopped", d, 32'd4);
      wr(A_CTRL, 32'h1);
   endtask

   task automatic t_user;
      logic [31:0] d;
      wr(A_SEL, 1);
      wr(A_SEL, 2, 1'b0);
      rd(A_SEL, d);       chk("R8 user write ignored", d, 32'd1);
      rd(A_SEL, d, 1'b0); chk("R8 user read zero", d, 32'd0);
      wr(A_UACC, 1);
      rd(A_SEL, d, 1'b0); chk("R8 user read allowed", d, 32'd1);
      wr(A_SEL, 2, 1'b0);
      rd(A_SEL, d);       chk("R8 user write allowed", d, 32'd2);
      wr(A_UACC, 0, 1'b0);
      rd(A_UACC, d);      chk("R8 user cannot change access bit", d, 32'd1);
      wr(A_UACC, 0);
      rd(A_UACC, d);      chk("R8 privileged clears access bit", d, 32'd0);
   endtask

   task automatic t_badsel;
      logic [31:0] d;
      wr(A_SEL, 4);
      rd(A_TYPE, d);  chk("R10 type read zero", d, 32'd0);
      rd(A_COUNT, d); chk("R10 count read zero", d, 32'd0);
      wr(A_COUNT, 32'h55); wr(A_TYPE, 3);
      wr(A_SEL, 32'h24);
      wr(A_COUNT, 32'h66);
      rd_ctr(0, d); chk("R10 counter0 untouched", d, 32'd4);
      rd(A_TYPE, d); chk("R10 type0 untouched", d, 32'd2);
      rd_ctr(3, d); chk("R10 counter3 untouched", d, 32'd4);
   endtask

   task automatic t_wrap;
      logic [31:0] d;
      wr(A_SEL, 0);
      wr(A_COUNT, 32'hFFFF_FFFF);
      rd(A_COUNT, d); chk("R5 count load", d, 32'hFFFF_FFFF);
      pulse(8'h04);
      rd(A_COUNT, d); chk("R9 wrap to zero", d, 32'h0);
   endtask

   task automatic t_priority;
      logic [31:0] d;
      wr(A_SEL, 0);
      wr(A_COUNT, 32'd10);
      evt_pulse = 8'h04;
      wr(A_CTRL, 32'h3);
      evt_pulse = '0;
      rd(A_COUNT, d); chk("R11 clear beats increment", d, 32'd0);
      evt_pulse = 8'h04;
      wr(A_COUNT, 32'd7);
      evt_pulse = '0;
      rd(A_COUNT, d); chk("R11 load beats increment", d, 32'd7);
      wr(A_CTRL, 32'h5);
      rd(A_CYC, d); chk("R11 cycle clear while running", d, 32'd0);
   endtask

   task automatic t_unused;
      logic [31:0] d;
      wr(4'd9, 32'hDEAD_BEEF);
      rd(4'd9, d);  chk("R13 unused address", d, 32'd0);
      rd(4'd12, d); chk("R13 unused address", d, 32'd0);
      rd(A_SEL, d); chk("R13 unused write no effect", d, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_control();
      t_mask();
      t_events();
      t_enable_off();
      t_user();
      t_badsel();
      t_wrap();
      t_priority();
      t_unused();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule